// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

The block holds four independent down-counters behind a small register bus. Software writes a start value, picks how the counter behaves when it reaches zero and how fast it counts, and then polls the counter or waits for the interrupt. A counter can stop at zero, reload a stored reload value, or wrap to all ones and keep counting. Each channel counts either 16 or 32 bits wide, and a per-channel prescaler divides the clock by 1, 16 or 256.

Four shared words handle interrupts: an enable mask, raw status, masked status and a write-one-to-clear word. One interrupt output is the OR of the masked status bits. Reads are registered, so read data is valid in the cycle after the read strobe.

Top module: `tmr_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is 0.
- R2: Byte addresses are fixed. Shared words are mask 0x00, raw 0x04, masked 0x08 and clear 0x0C. Channel n uses base 0x10*(n+1) with offsets +0x0 load, +0x4 current value, +0x8 control and +0xC reload. `bus_rdata` shows the addressed word in the cycle after `bus_re`. Control bits 7, 6, 3:2, 1 and 0 read back as written, and bits 5:4 read back as 0.
- R3: A write to the load word sets both the current value and the reload value. A write to the reload word changes only the reload value. Reading the load word returns the reload value.
- R4: Control bit 7 enables counting, and each prescaled tick lowers the counter by one. Bits 3:2 set the division: 00 gives 1, 01 gives 16, and 10 or 11 give 256. The first tick comes that many cycles after the edge that writes control or load. While the channel is disabled, the value holds.
- R5: With control bit 6 clear (free-running), a tick at zero wraps the counter to all ones of the active width.
- R6: With bit 6 set (periodic), a tick at zero loads the reload value.
- R7: With bit 0 set (one-shot), the counter stops at zero, raises its status once, and runs again only after a load write. Bit 0 takes priority over bit 6.
- R8: With bit 1 clear, only the low 16 bits count and wrap, and the current value reads with bits 31:16 as 0. With bit 1 set, all 32 bits count.
- R9: A tick that takes channel n from 1 to 0 sets raw status bit n on that same edge.
- R10: Writing 1 to bit n of the clear word clears raw bit n. Writing 0 leaves the bit unchanged.
- R11: Masked status is raw AND mask, using bits 3:0. `irq` is the OR of the masked bits and is registered, so it follows one cycle later.
- R12: Counting on one channel never changes the value of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The bench sweeps all three prescaler settings on every channel. It derives each expected count from the number of edges since the arming write, which exposes an off-by-one in the prescaler, since that would shift every value by a whole tick period. The 32-bit wrap, the 16-bit wrap and the periodic reload are each checked past zero. A design that reloads from the wrong source, or that leaks the upper half in 16-bit mode, would read back the wrong value. The bench also re-reads a finished one-shot channel after its status is cleared, which would reveal a counter that restarts or sets status again. The clear-with-zero and mask cases confirm that `irq` tracks only the enabled raw bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [1:0] rsv;
    logic [1:0] psc;
    logic       wide;
    logic       oneshot;
  } ctl_t;

  localparam logic [7:0] CTL_RW_MASK = 8'hCF;

  typedef enum logic [1:0] {W_LOAD = 2'd0, W_CUR = 2'd1, W_CTL = 2'd2, W_BG = 2'd3} ch_word_e;
  typedef enum logic [1:0] {S_MASK = 2'd0, S_RAW = 2'd1, S_MIS = 2'd2, S_CLR = 2'd3} sh_word_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam logic [PSC_W-1:0] LIM16  = PSC_W'(15);
  localparam logic [PSC_W-1:0] LIM256 = PSC_W'(255);

  logic [PSC_W-1:0] cnt, lim;

  always_comb begin
    case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = LIM16;
      default: lim = LIM256;
    endcase
  end

  assign tick = run && !restart && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) cnt <= '0;
    else                                cnt <= cnt + PSC_W'(1);
  end

  // R4
  psc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != 2'b00 && !restart) |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic             bg_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cur_rd,
  output logic [CNT_W-1:0] bg_rd,
  output ctl_t             ctl_rd,
  output logic             evt
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, bg_q, wmask, cnt_val, cnt_nxt;
  ctl_t             ctl_q;
  logic             run, tick;

  assign wmask   = ctl_q.wide ? {CNT_W{1'b1}} : {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};
  assign cnt_val = cnt_q & wmask;
  assign run     = ctl_q.en && !(ctl_q.oneshot && cnt_val == '0);

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(run), .restart(ld_we | ctl_we),
    .sel(ctl_q.psc), .tick(tick)
  );

  always_comb begin
    if (cnt_val != '0)      cnt_nxt = cnt_val - CNT_W'(1);
    else if (ctl_q.periodic) cnt_nxt = bg_q & wmask;
    else                     cnt_nxt = wmask;
  end

  assign evt = tick && (cnt_val == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bg_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (ld_we) begin
        cnt_q <= wdata;
        bg_q  <= wdata;
      end else begin
        if (tick)  cnt_q <= cnt_nxt;
        if (bg_we) bg_q  <= wdata;
      end
      if (ctl_we) ctl_q <= ctl_t'(wdata[7:0] & CTL_RW_MASK);
    end
  end

  assign cur_rd = cnt_val;
  assign bg_rd  = bg_q;
  assign ctl_rd = ctl_q;

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> (cnt_q == $past(wdata) && bg_q == $past(wdata)));
  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_val != '0 && !ld_we && !ctl_we) |=> (cnt_val == $past(cnt_val) - CNT_W'(1)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_we) |=> (cnt_q == $past(cnt_q)));
  // R7
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.oneshot && cnt_val == '0 && !ld_we && !ctl_we) |=> (cnt_val == '0));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] raw_q,
  output logic              irq
);
  logic [NUM_CH-1:0] clr_bits;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      raw_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      raw_q <= (raw_q & ~clr_bits) | evt;
      irq   <= |(raw_q & mask_q);
    end
  end

  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));
  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((raw_q & $past(wdata & ~evt)) == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        wd;
  logic [1:0]        unused_lsb;
  logic [NUM_CH-1:0] evt, mask_q, raw_q;
  logic [CNT_W-1:0]  cur_rd [NUM_CH];
  logic [CNT_W-1:0]  bg_rd  [NUM_CH];
  ctl_t              ctl_rd [NUM_CH];
  logic [CNT_W-1:0]  rd_mux;

  assign blk        = bus_addr[ADDR_W-1:4];
  assign wd         = bus_addr[3:2];
  assign unused_lsb = bus_addr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = (blk == BLK_W'(i + 1));
    tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
      .clk(clk), .rst(rst),
      .ld_we (bus_we && sel && wd == W_LOAD),
      .bg_we (bus_we && sel && wd == W_BG),
      .ctl_we(bus_we && sel && wd == W_CTL),
      .wdata(bus_wdata),
      .cur_rd(cur_rd[i]), .bg_rd(bg_rd[i]), .ctl_rd(ctl_rd[i]),
      .evt(evt[i])
    );
  end

  tmr_irq_ctl #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .evt(evt),
    .mask_we(bus_we && blk == '0 && wd == S_MASK),
    .clr_we (bus_we && blk == '0 && wd == S_CLR),
    .wdata(bus_wdata[NUM_CH-1:0]),
    .mask_q(mask_q), .raw_q(raw_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (blk == '0) begin
      case (wd)
        S_MASK:  rd_mux = CNT_W'(mask_q);
        S_RAW:   rd_mux = CNT_W'(raw_q);
        S_MIS:   rd_mux = CNT_W'(raw_q & mask_q);
        default: rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (blk == BLK_W'(i + 1)) begin
          case (wd)
            W_CUR:   rd_mux = cur_rd[i];
            W_CTL:   rd_mux = CNT_W'(ctl_rd[i]);
            default: rd_mux = bg_rd[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_unit u_tmr_unit (.clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .irq(irq));

  function automatic int cha(int ch, int w);
    return 16 * (ch + 1) + 4 * w;
  endfunction

  // mode 0 free-running, 1 periodic, 2 one-shot; n = ticks since arming
  function automatic longint model(int mode, longint l, longint bg, longint n, bit wide);
    longint m = wide ? 64'h1_0000_0000 : 64'h1_0000;
    l = l % m; bg = bg % m;
    if (mode == 0) return (((l - n) % m) + m) % m;
    if (mode == 2) return (n >= l) ? 0 : l - n;
    if (n <= l) return l - n;
    return bg - ((n - l - 1) % (bg + 1));
  endfunction

  task automatic wr(input int a, input logic [31:0] d, output int w);
    @(negedge clk); addr = 7'(a); wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk); w = cyc; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v, output int r);
    @(negedge clk); addr = 7'(a); re = 1'b1;
    @(posedge clk); @(negedge clk); r = cyc; v = rdata; re = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int w, w2, r, dv, n;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    chk("R1 irq after reset", {31'd0, irq}, 0);
    for (int a = 0; a < 80; a += 4) begin
      rd(a, v, r);
      chk("R1 reset register", v, 0);
    end

    // R4 R5 R9 R12 sweep of every channel and prescaler
    for (int ch = 0; ch < 4; ch++) begin
      for (int p = 0; p < 3; p++) begin
        dv = (p == 0) ? 1 : (p == 1) ? 16 : 256;
        wr(cha(ch, 0), 5, w);
        wr(cha(ch, 2), 32'h82 | (p << 2), w);
        rd(cha(ch, 2), v, r);
        chk("R2 control readback", v, 32'h82 | (p << 2));
        for (int k = 0; k < 4; k++) begin
          idle(dv * 2);
          rd(cha(ch, 1), v, r);
          n = (r - 1 - w) / dv;
          chk("R4 R5 count value", v, 32'(model(0, 5, 5, n, 1)));
        end
        rd(0, v, r); v = v; rd(4, v, r);
        n = (r - 1 - w) / dv;
        chk("R9 raw bit", v & (1 << ch), (n >= 5) ? (1 << ch) : 0);
        wr(cha(ch, 2), 32'h02, w2);
        n = (w2 - 1 - w) / dv;
        idle(3 * dv);
        rd(cha(ch, 1), v, r);
        chk("R4 disabled hold", v, 32'(model(0, 5, 5, n, 1)));
        if (ch < 3) begin
          rd(cha(ch + 1, 1), v, r);
          chk("R12 other channel untouched", v, 0);
        end
        wr(12, 32'(1 << ch), w2);
        rd(4, v, r);
        chk("R10 clear raw", v, 0);
      end
    end

    wr(cha(0, 2), 32'h30, w);
    rd(cha(0, 2), v, r);
    chk("R2 reserved control bits", v, 0);

    // R3
    wr(cha(1, 0), 32'h0ABC0002, w);
    rd(cha(1, 3), v, r); chk("R3 load sets reload", v, 32'h0ABC0002);
    rd(cha(1, 0), v, r); chk("R3 load word reads reload", v, 32'h0ABC0002);
    wr(cha(1, 3), 32'h77, w);
    rd(cha(1, 1), v, r); chk("R3 reload write keeps count", v, 32'h0ABC0002);
    rd(cha(1, 3), v, r); chk("R3 reload write", v, 32'h77);

    // R8 16-bit wrap
    wr(cha(1, 0), 32'h0ABC0002, w);
    wr(cha(1, 2), 32'h80, w);
    for (int k = 0; k < 3; k++) begin
      idle(3);
      rd(cha(1, 1), v, r);
      n = r - 1 - w;
      chk("R8 16-bit count", v, 32'(model(0, 32'h0ABC0002, 0, n, 0)));
    end
    wr(cha(1, 2), 32'h02, w);
    rd(4, v, r); chk("R9 16-bit zero status", v, 32'h2);
    wr(12, 32'h2, w);

    // R6 periodic
    wr(cha(2, 0), 3, w);
    wr(cha(2, 3), 2, w);
    rd(cha(2, 1), v, r); chk("R3 count kept", v, 3);
    wr(cha(2, 2), 32'hC2, w);
    for (int k = 0; k < 6; k++) begin
      idle(1);
      rd(cha(2, 1), v, r);
      n = r - 1 - w;
      chk("R6 periodic value", v, 32'(model(1, 3, 2, n, 1)));
    end
    wr(cha(2, 2), 32'h02, w);
    wr(12, 32'h4, w);

    // R7 one-shot (periodic bit also set)
    wr(cha(3, 0), 4, w);
    wr(cha(3, 2), 32'hC3, w);
    rd(cha(3, 1), v, r);
    chk("R7 one-shot early", v, 32'(model(2, 4, 4, r - 1 - w, 1)));
    idle(10);
    rd(cha(3, 1), v, r); chk("R7 one-shot stops", v, 0);
    rd(4, v, r); chk("R9 one-shot status", v, 32'h8);
    wr(12, 32'h8, w);
    idle(10);
    rd(4, v, r); chk("R7 status only once", v, 0);
    rd(cha(3, 1), v, r); chk("R7 still stopped", v, 0);
    wr(cha(3, 0), 1, w);
    idle(5);
    rd(4, v, r); chk("R7 rearm by load", v, 32'h8);

    // R11 R10 mask, irq, clear
    rd(8, v, r); chk("R11 masked with mask 0", v, 0);
    chk("R11 irq masked off", {31'd0, irq}, 0);
    wr(0, 32'h8, w);
    idle(2);
    chk("R11 irq on", {31'd0, irq}, 1);
    rd(8, v, r); chk("R11 masked status", v, 32'h8);
    rd(0, v, r); chk("R2 mask readback", v, 32'h8);
    wr(12, 32'h0, w);
    rd(4, v, r); chk("R10 zero write no effect", v, 32'h8);
    wr(12, 32'h8, w);
    idle(2);
    chk("R11 irq off after clear", {31'd0, irq}, 0);
    rd(4, v, r); chk("R10 cleared", v, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule